// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

This block is one down-counting timer channel that doubles as a pulse-width generator. A simple write port fills three registers: a low-phase reload value, a high-phase reload value and a four-bit control word. Once enabled, the counter drops by one on every clock. When it reaches zero it reloads, and the output flips each time that happens.

In pulse-width mode the two reload values set the widths of the low phase and the high phase independently. Each phase lasts at least one clock, so the output never sits at a constant level while it runs. Without pulse-width mode, the channel is a periodic timer. In user mode it reloads from the low-phase value. In free-running mode it wraps to the all-ones value. The current count can be read at any time.

Each expiry can set a sticky raw interrupt flag. A one-cycle end-of-interrupt strobe clears the flag. The interrupt pin is the flag gated by a mask bit.

Top module: `pwm_timer_channel`

## Requirements
- R1: The write select picks the target register: 0 for the low-phase reload, 1 for the high-phase reload, 2 for the control word. In the control word, bit 0 is enable, bit 1 is mode (1 = user reload, 0 = free-running wrap), bit 2 is interrupt mask (1 = masked) and bit 3 is pulse-width mode. Pulse-width mode applies only in user mode.
- R2: After reset the count is 0, the output is low, and both the raw flag and the interrupt are low.
- R3: A control write that sets enable while the channel is disabled loads the low-phase reload into the counter and starts in the low phase. On the next cycle the count reads back that value and the output is low.
- R4: In pulse-width mode the output stays low for low-reload + 1 clocks, then high for high-reload + 1 clocks, and keeps alternating. A reload of 0 gives a one-clock phase.
- R5: In user mode without pulse-width mode, the counter reloads from the low-phase value at zero and the output toggles on every expiry.
- R6: In free-running mode, a count of zero is followed by the all-ones value and the output toggles.
- R7: Writing a reload value while the channel runs does not restart the count. The new value takes effect at the next reload that uses it.
- R8: Clearing enable freezes the count at its current value and drives the output low from the next cycle.
- R9: The raw flag is set on every expiry in timer modes, and only at the end of each high phase in pulse-width mode. The end-of-interrupt strobe clears it. When a strobe and a flag-setting expiry fall in the same cycle, the flag stays set.
- R10: The interrupt output equals the raw flag while the mask bit is 0, and stays low while the mask bit is 1.
- R11: While enabled, the count drops by exactly one per clock until it reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 low reload, 1 high reload, 2 control) |
| wr_data | input | CNT_W | Write data; control uses bits 3:0 |
| eoi | input | 1 | End-of-interrupt strobe, clears the raw flag |
| cur_val | output | CNT_W | Current counter value |
| pwm_out | output | 1 | Timer / pulse-width output |
| irq_raw | output | 1 | Sticky raw interrupt flag |
| irq | output | 1 | Raw flag gated by the mask bit |

## Verification
The bound assertions check the cycle-by-cycle rules on every edge:
- the reset state;
- the one-per-clock decrement;
- the all-ones wrap in free-running mode;
- the frozen count while disabled;
- the sticky raw flag;
- that the output rises only after the count reaches zero.

Phase widths, restart on enable, late reload writes, masking, and strobe-versus-expiry priority depend on sequences of register writes. Only the bench scenarios show these, by measuring run lengths of the output against the programmed reload values.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  // Control word: bit 0 enable, bit 1 user mode, bit 2 mask, bit 3 pwm mode
  typedef struct packed {
    logic pwm;
    logic mask;
    logic user;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = 4;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] load_lo,
  output logic [CNT_W-1:0] load_hi,
  output ctrl_t            ctrl,
  output logic             start
);

  logic  ctrl_wr;
  ctrl_t ctrl_new;

  assign ctrl_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
  // Restart only when enable goes from clear to set
  assign start    = ctrl_wr && ctrl_new.en && !ctrl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_lo <= '0;
      load_hi <= '0;
      ctrl    <= '0;
    end else if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_LOW:  load_lo <= wr_data;
        SEL_HIGH: load_hi <= wr_data;
        SEL_CTRL: ctrl    <= ctrl_new;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             en,
  input  logic             user_mode,
  input  logic             pwm_mode,
  input  logic [CNT_W-1:0] load_lo,
  input  logic [CNT_W-1:0] load_hi,
  output logic [CNT_W-1:0] count,
  output logic             phase,
  output logic             expire,
  output logic             period_end
);

  localparam logic [CNT_W-1:0] WRAP_VAL = '1;

  logic             dual;
  logic [CNT_W-1:0] reload_val;

  assign dual = user_mode && pwm_mode;

  always_comb begin
    if (!user_mode)          reload_val = WRAP_VAL;
    else if (dual && !phase) reload_val = load_hi;
    else                     reload_val = load_lo;
  end

  assign expire     = en && !start && (count == '0);
  assign period_end = expire && (!dual || phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      phase <= 1'b0;
    end else if (start) begin
      count <= load_lo;
      phase <= 1'b0;
    end else if (en) begin
      if (count == '0) begin
        count <= reload_val;
        phase <= ~phase;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_irq_flag.sv
module pwm_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic raw,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst)      raw <= 1'b0;
    else if (set) raw <= 1'b1;
    else if (clr) raw <= 1'b0;
  end

  assign irq = raw & ~mask;

endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             eoi,
  output logic [CNT_W-1:0] cur_val,
  output logic             pwm_out,
  output logic             irq_raw,
  output logic             irq
);

  logic [CNT_W-1:0] load_lo;
  logic [CNT_W-1:0] load_hi;
  ctrl_t            ctrl_q;
  logic             start;
  logic [CNT_W-1:0] count;
  logic             phase;
  logic             expire;
  logic             period_end;

  pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .load_lo (load_lo),
    .load_hi (load_hi),
    .ctrl    (ctrl_q),
    .start   (start)
  );

  pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .en         (ctrl_q.en),
    .user_mode  (ctrl_q.user),
    .pwm_mode   (ctrl_q.pwm),
    .load_lo    (load_lo),
    .load_hi    (load_hi),
    .count      (count),
    .phase      (phase),
    .expire     (expire),
    .period_end (period_end)
  );

  pwm_irq_flag u_irq (
    .clk  (clk),
    .rst  (rst),
    .set  (period_end),
    .clr  (eoi),
    .mask (ctrl_q.mask),
    .raw  (irq_raw),
    .irq  (irq)
  );

  assign cur_val = count;
  assign pwm_out = ctrl_q.en & phase;

  logic unused_expire;
  assign unused_expire = expire;

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             eoi,
  input logic             ctrl_en,
  input logic             ctrl_user,
  input logic [CNT_W-1:0] cur_val,
  input logic             pwm_out,
  input logic             irq_raw
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_sel == 2'd2);

  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (cur_val == '0 && !pwm_out && !irq_raw));

  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && cur_val != '0 && !ctrl_wr) |=> cur_val == CNT_W'($past(cur_val) - 1'b1));

  assert_free_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !ctrl_user && cur_val == '0 && !ctrl_wr) |=> (&cur_val));

  assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !ctrl_wr) |=> $stable(cur_val));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_raw && !eoi) |=> irq_raw);

  assert_rise_after_zero_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> $past(cur_val) == '0);

endmodule

bind pwm_timer_channel pwm_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .eoi       (eoi),
  .ctrl_en   (ctrl_q.en),
  .ctrl_user (ctrl_q.user),
  .cur_val   (cur_val),
  .pwm_out   (pwm_out),
  .irq_raw   (irq_raw)
);

// File: tb/test_pwm_timer_channel.sv
`timescale 1ns/1ps
module test_pwm_timer_channel;

  localparam int CNT_W = 16;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             eoi = 1'b0;
  logic [CNT_W-1:0] cur_val;
  logic             pwm_out;
  logic             irq_raw;
  logic             irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pwm_timer_channel #(.CNT_W(CNT_W)) i_pwm_timer_channel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .eoi(eoi), .cur_val(cur_val), .pwm_out(pwm_out), .irq_raw(irq_raw), .irq(irq)
  );

  // Expected-value helpers derived from the requirements
  function automatic int phase_len(input int reload);
    return reload + 1;
  endfunction

  function automatic logic [CNT_W-1:0] ctrl_word(input bit pwm, input bit msk,
                                                  input bit user, input bit en);
    return CNT_W'({pwm, msk, user, en});
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic measure(input logic level, output int n);
    n = 0;
    while (pwm_out === level && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_level(input logic level);
    int guard = 0;
    while (pwm_out !== level && guard < 2000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic start_chan(input int lo, input int hi, input logic [CNT_W-1:0] c);
    write_reg(2'd2, '0);
    pulse_eoi();
    write_reg(2'd0, CNT_W'(lo));
    write_reg(2'd1, CNT_W'(hi));
    write_reg(2'd2, c);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    int n;
    int v;
    int rnd;
    rnd = int'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    check("R2 cur_val", int'(cur_val), 0);
    check("R2 pwm_out", int'(pwm_out), 0);
    check("R2 irq_raw", int'(irq_raw), 0);
    check("R2 irq", int'(irq), 0);

    // R1 R3 R4 R9 R10: directed pulse-width run, low=3 high=1
    start_chan(3, 1, ctrl_word(1, 0, 1, 1));
    check("R3 load on enable", int'(cur_val), 3);
    check("R3 starts low", int'(pwm_out), 0);
    measure(1'b0, n); check("R4 low width", n, phase_len(3));
    check("R9 no flag mid period", int'(irq_raw), 0);
    measure(1'b1, n); check("R4 high width", n, phase_len(1));
    check("R9 flag at period end", int'(irq_raw), 1);
    check("R10 irq unmasked", int'(irq), 1);
    measure(1'b0, n); check("R4 second low", n, phase_len(3));
    measure(1'b1, n); check("R4 second high", n, phase_len(1));

    // R4 random widths including zero reloads
    for (int i = 0; i < 20; i++) begin
      int lo, hi;
      lo = int'($urandom % 8);
      hi = int'($urandom % 8);
      start_chan(lo, hi, ctrl_word(1, 0, 1, 1));
      measure(1'b0, n); check("R4 rand low", n, phase_len(lo));
      measure(1'b1, n); check("R4 rand high", n, phase_len(hi));
      check("R9 rand period flag", int'(irq_raw), 1);
    end

    // R7 reload write while running
    start_chan(2, 4, ctrl_word(1, 0, 1, 1));
    wait_level(1'b1);
    write_reg(2'd0, CNT_W'(5));
    wait_level(1'b0);
    measure(1'b0, n); check("R7 new low width", n, phase_len(5));
    measure(1'b1, n); check("R7 high unchanged", n, phase_len(4));

    // R5 user timer mode, toggles every expiry
    start_chan(2, 7, ctrl_word(0, 0, 1, 1));
    measure(1'b0, n); check("R5 first span", n, phase_len(2));
    check("R9 timer expiry flag", int'(irq_raw), 1);
    measure(1'b1, n); check("R5 second span", n, phase_len(2));

    // R10 mask gating without restart
    write_reg(2'd2, ctrl_word(0, 1, 1, 1));
    check("R10 masked irq", int'(irq), 0);
    check("R10 raw kept", int'(irq_raw), 1);
    write_reg(2'd2, ctrl_word(0, 0, 1, 1));
    check("R10 unmasked again", int'(irq), 1);

    // R9 expiry beats eoi in the same cycle, reload 0 expires every clock
    start_chan(0, 0, ctrl_word(0, 0, 1, 1));
    @(negedge clk);
    eoi = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R9 set wins over clear", int'(irq_raw), 1);
    end
    eoi = 1'b0;
    write_reg(2'd2, '0);
    pulse_eoi();
    check("R9 clear when idle", int'(irq_raw), 0);

    // R6 free-running wrap and R11 step
    start_chan(3, 0, ctrl_word(0, 0, 0, 1));
    check("R3 free load", int'(cur_val), 3);
    @(negedge clk); check("R11 step", int'(cur_val), 2);
    repeat (2) @(negedge clk);
    check("R11 reach zero", int'(cur_val), 0);
    @(negedge clk);
    check("R6 wrap value", int'(cur_val), MAXV);
    check("R6 output toggled", int'(pwm_out), 1);
    check("R9 free expiry flag", int'(irq_raw), 1);
    @(negedge clk); check("R11 after wrap", int'(cur_val), MAXV - 1);

    // R8 disable freezes the count and forces output low
    write_reg(2'd2, '0);
    check("R8 output low", int'(pwm_out), 0);
    v = int'(cur_val);
    repeat (5) @(negedge clk);
    check("R8 frozen", int'(cur_val), v);

    // R3 re-enable reloads from the low reload
    write_reg(2'd2, ctrl_word(0, 0, 0, 1));
    check("R3 reload on re-enable", int'(cur_val), 3);

    done = 1'b1;
    report();
    $finish;
  end

endmodule